// File: doc/BRIEF.md
# MII Management Register Front-End

This block sits between a host register bus and a behavioural stand-in for an Ethernet PHY's management registers. The host places a PHY register number in an address register, then either raises the read bit of a command register to fetch a 16-bit PHY value into a status register, or writes a control register to push 16 bits of data into the PHY. Every management cycle finishes in the same clock edge that accepts the host write, so no busy flag exists. A link input is sampled every clock and shows up as the link bit of the PHY status value.

The host write port is decoded into one of three operation kinds, the only "states" of this block. MG_IDLE applies when no management cycle is due. MG_READ is selected when a command write raises the read bit from 0 to 1. MG_WRITE is selected by any control-register write. Each kind returns to MG_IDLE on the next clock, because nothing is held between cycles. Two further host registers use generic access rules: a read/write scratch register and a flag register cleared by writing ones. A fixed identification word is read-only.

Host register indices: 0 command, 1 address, 2 control, 3 status, 4 scratch, 5 flags, 6 identification. Writes are accepted on the rising clock edge when `wr_en` is high. `rd_data` is combinational from `rd_idx`.

Top module: `mii_mgmt_frontend`

## Requirements
- R1: After reset, the command, address, control, status, scratch and flag registers read 0, the stored PHY control value is 0, and index 6 reads the identification word (default 32'h00A5_0001).
- R2: The command register (index 0) stores every written word. A read cycle starts only when the written bit 0 is 1 and the stored bit 0 is 0. Rewriting 1 over 1 leaves the status register unchanged.
- R3: A read cycle uses PHY register number address[4:0] and loads the status register (index 3, bits 15:0, upper bits 0) on the edge that accepts the command write. Number 0 returns the PHY control value, 1 returns the PHY status value, 10 returns 16'h3000, and any other number returns 0. The PHY number in address[12:8] has no effect.
- R4: A write to the control register (index 2) stores wr_data[15:0] with bits 31:16 read as 0.
- R5: Every control write is a write cycle. With PHY register number 0, it sets the PHY control value to wr_data[15:0] with bit 15 and bit 8 cleared. With any other number, it leaves the PHY control value unchanged.
- R6: The PHY status value is 16'h0004 when link_up was 1 at the previous clock edge, and 16'h0000 when it was 0.
- R7: The scratch register (index 4) stores and returns the written word.
- R8: The flag register (index 5) gains every bit that is 1 on flag_set at a clock edge. A write clears every bit written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R9: Writes to index 3, index 6 and unused indices 7 to 15 change nothing. Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | IDX_W (4) | Host write register index |
| wr_data | input | DATA_W (32) | Host write data |
| rd_idx | input | IDX_W (4) | Host read register index |
| rd_data | output | DATA_W (32) | Host read data, combinational |
| link_up | input | 1 | Link state from the network side, 1 = up |
| flag_set | input | DATA_W (32) | Per-bit set requests for the flag register |

## Verification
The bench rewrites a 1 over a stored command read bit after changing the address. A design that detected a level rather than an edge would load the new register's value into status, where the bench expects the old value. It writes all ones and a value with bits 15 and 8 set into PHY register 0. A design that failed to mask those bits would return them in a later read. It also sends a control write to a nonzero PHY register, which a sloppy decode would let overwrite the control value. The link is toggled and read back through PHY register 1. The flag register is set and cleared in the same cycle to show that the set wins. A write to the read-only indices is followed by a readback that would expose a store.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    // Management operation kinds chosen per host write
    typedef enum logic [1:0] {
        MG_IDLE,
        MG_READ,
        MG_WRITE
    } mg_op_e;

    // Access rule of a generic host register
    typedef enum logic {
        ACC_RW,
        ACC_W1C
    } acc_e;

    // Host register indices
    localparam int IDX_CMD     = 0;
    localparam int IDX_ADDR    = 1;
    localparam int IDX_CTRL    = 2;
    localparam int IDX_STAT    = 3;
    localparam int IDX_SCRATCH = 4;
    localparam int IDX_FLAGS   = 5;
    localparam int IDX_ID      = 6;

    // PHY register numbers with a defined response
    localparam logic [4:0] PHY_REG_CTRL  = 5'd0;
    localparam logic [4:0] PHY_REG_STAT  = 5'd1;
    localparam logic [4:0] PHY_REG_GSTAT = 5'd10;

    localparam int          PHY_W        = 16;
    localparam logic [15:0] CTRL_DROP    = 16'h8100;  // reset and duplex bits
    localparam logic [15:0] GSTAT_VALUE  = 16'h3000;  // both receivers OK
    localparam int          LINK_BIT     = 2;

endpackage

// File: rtl/mii_mgmt_decode.sv
module mii_mgmt_decode
    import mii_mgmt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_rd_bit,
    input  logic             cmd_rd_q,
    output mg_op_e           op
);

    always_comb begin
        op = MG_IDLE;
        if (wr_en) begin
            case (wr_idx)
                IDX_W'(IDX_CMD):  op = (wr_rd_bit && !cmd_rd_q) ? MG_READ : MG_IDLE;
                IDX_W'(IDX_CTRL): op = MG_WRITE;
                default:          op = MG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
    import mii_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mg_op_e           op,
    input  logic [4:0]       reg_sel,
    input  logic [PHY_W-1:0] wdata,
    input  logic             link_up,
    output logic [PHY_W-1:0] phy_ctrl,
    output logic [PHY_W-1:0] phy_stat,
    output logic [PHY_W-1:0] result_q
);

    logic             link_q;
    logic [PHY_W-1:0] rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_up;
    end

    always_comb begin
        phy_stat           = '0;
        phy_stat[LINK_BIT] = link_q;
    end

    always_comb begin
        case (reg_sel)
            PHY_REG_CTRL:  rd_val = phy_ctrl;
            PHY_REG_STAT:  rd_val = phy_stat;
            PHY_REG_GSTAT: rd_val = GSTAT_VALUE;
            default:       rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_ctrl <= '0;
            result_q <= '0;
        end else begin
            unique case (op)
                MG_READ:  result_q <= rd_val;
                MG_WRITE: if (reg_sel == PHY_REG_CTRL) phy_ctrl <= wdata & ~CTRL_DROP;
                MG_IDLE:  ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/mii_gen_reg.sv
module mii_gen_reg
    import mii_mgmt_pkg::*;
#(
    parameter int   W   = 32,
    parameter acc_e ACC = ACC_RW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] q
);

    logic [W-1:0] base;

    generate
        if (ACC == ACC_W1C) begin : g_w1c
            assign base = we ? (q & ~wdata) : q;
        end else begin : g_rw
            assign base = we ? wdata : q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= base | set_bits;
    end

endmodule

// File: rtl/mii_mgmt_frontend.sv
module mii_mgmt_frontend
    import mii_mgmt_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              IDX_W    = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h00A5_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              link_up,
    input  logic [DATA_W-1:0] flag_set
);

    localparam int PAD_W  = DATA_W - PHY_W;
    localparam int BANK_N = 2;

    logic [DATA_W-1:0] cmd_q, addr_q, ctrl_q;
    logic [PHY_W-1:0]  phy_ctrl, phy_stat, stat_res;
    logic [DATA_W-1:0] bank_q [BANK_N];
    mg_op_e            op;

    mii_mgmt_decode #(.IDX_W(IDX_W)) u_dec (
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_rd_bit (wr_data[0]),
        .cmd_rd_q  (cmd_q[0]),
        .op        (op)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == IDX_W'(IDX_CMD))  cmd_q  <= wr_data;
            if (wr_idx == IDX_W'(IDX_ADDR)) addr_q <= wr_data;
            if (wr_idx == IDX_W'(IDX_CTRL)) ctrl_q <= {{PAD_W{1'b0}}, wr_data[PHY_W-1:0]};
        end
    end

    mii_phy_model u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .reg_sel  (addr_q[4:0]),
        .wdata    (wr_data[PHY_W-1:0]),
        .link_up  (link_up),
        .phy_ctrl (phy_ctrl),
        .phy_stat (phy_stat),
        .result_q (stat_res)
    );

    generate
        for (genvar g = 0; g < BANK_N; g++) begin : g_bank
            localparam acc_e ACC = (g == 0) ? ACC_RW : ACC_W1C;
            localparam int   IDX = IDX_SCRATCH + g;
            mii_gen_reg #(.W(DATA_W), .ACC(ACC)) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (wr_en && (wr_idx == IDX_W'(IDX))),
                .wdata    (wr_data),
                .set_bits ((ACC == ACC_W1C) ? flag_set : {DATA_W{1'b0}}),
                .q        (bank_q[g])
            );
        end
    endgenerate

    always_comb begin
        case (rd_idx)
            IDX_W'(IDX_CMD):     rd_data = cmd_q;
            IDX_W'(IDX_ADDR):    rd_data = addr_q;
            IDX_W'(IDX_CTRL):    rd_data = ctrl_q;
            IDX_W'(IDX_STAT):    rd_data = {{PAD_W{1'b0}}, stat_res};
            IDX_W'(IDX_SCRATCH): rd_data = bank_q[0];
            IDX_W'(IDX_FLAGS):   rd_data = bank_q[1];
            IDX_W'(IDX_ID):      rd_data = ID_VALUE;
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mii_mgmt_frontend_chk.sv
module mii_mgmt_frontend_chk
    import mii_mgmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_up,
    input logic [DATA_W-1:0] flag_set,
    input logic [DATA_W-1:0] cmd_q,
    input logic [4:0]        addr_sel,
    input logic [15:0]       phy_ctrl,
    input logic [15:0]       phy_stat,
    input logic [15:0]       stat_q,
    input logic [DATA_W-1:0] flags_q
);

    logic cmd_wr, ctrl_wr, flag_wr;
    assign cmd_wr  = wr_en && (wr_idx == IDX_W'(IDX_CMD));
    assign ctrl_wr = wr_en && (wr_idx == IDX_W'(IDX_CTRL));
    assign flag_wr = wr_en && (wr_idx == IDX_W'(IDX_FLAGS));

    p_cmd_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (cmd_q == $past(wr_data)));

    p_no_retrigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[0] && cmd_q[0]) |=> $stable(stat_q));

    p_ctrl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && addr_sel == 5'd0) |=> (phy_ctrl == ($past(wr_data[15:0]) & 16'h7EFF)));

    p_ctrl_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && addr_sel != 5'd0) |=> $stable(phy_ctrl));

    p_link_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phy_stat == {13'b0, $past(link_up), 2'b0}));

    p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_set == '0) |=> (flags_q == ($past(flags_q) & ~$past(wr_data))));

endmodule

bind mii_mgmt_frontend mii_mgmt_frontend_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .link_up  (link_up),
    .flag_set (flag_set),
    .cmd_q    (cmd_q),
    .addr_sel (addr_q[4:0]),
    .phy_ctrl (phy_ctrl),
    .phy_stat (phy_stat),
    .stat_q   (stat_res),
    .flags_q  (bank_q[1])
);

// File: tb/mii_mgmt_frontend_test.sv
module mii_mgmt_frontend_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID_EXP = 32'h00A5_0001;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  idx;
        logic [31:0] val;   // write data or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    // idx: 0 cmd, 1 addr, 2 ctrl, 3 status, 4 scratch, 5 flags, 6 id
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1, 32'h0000_1F00, 8'd3},  // R3 phy 31, reg 0
        '{1'b1, 4'd2, 32'hFFFF_FFFF, 8'd5},  // R5 all ones into reg 0
        '{1'b0, 4'd2, 32'h0000_FFFF, 8'd4},  // R4 low half kept
        '{1'b1, 4'd0, 32'h0000_0001, 8'd3},  // read reg 0
        '{1'b0, 4'd3, 32'h0000_7EFF, 8'd5},  // R5 bits 15 and 8 dropped
        '{1'b1, 4'd1, 32'h0000_0003, 8'd5},
        '{1'b1, 4'd2, 32'h0000_1234, 8'd5},  // R5 write to reg 3 ignored
        '{1'b1, 4'd1, 32'h0000_0000, 8'd3},
        '{1'b1, 4'd0, 32'h0000_0000, 8'd2},
        '{1'b1, 4'd0, 32'h0000_0001, 8'd2},
        '{1'b0, 4'd3, 32'h0000_7EFF, 8'd5},
        '{1'b1, 4'd1, 32'h0000_000A, 8'd2},
        '{1'b1, 4'd0, 32'h0000_0001, 8'd2},  // R2 1 over 1: no read
        '{1'b0, 4'd3, 32'h0000_7EFF, 8'd2},
        '{1'b0, 4'd0, 32'h0000_0001, 8'd2},
        '{1'b1, 4'd0, 32'h0000_0002, 8'd2},
        '{1'b1, 4'd0, 32'h0000_0003, 8'd3},  // R3 read reg 10
        '{1'b0, 4'd0, 32'h0000_0003, 8'd2},
        '{1'b0, 4'd3, 32'h0000_3000, 8'd3},
        '{1'b1, 4'd1, 32'h0000_1F05, 8'd3},
        '{1'b1, 4'd0, 32'h0000_0000, 8'd3},
        '{1'b1, 4'd0, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd3, 32'h0000_0000, 8'd3},  // R3 other reg reads 0
        '{1'b1, 4'd1, 32'h0000_0200, 8'd5},  // phy 2, reg 0
        '{1'b1, 4'd2, 32'h0000_8140, 8'd5},
        '{1'b1, 4'd0, 32'h0000_0000, 8'd5},
        '{1'b1, 4'd0, 32'h0000_0001, 8'd5},
        '{1'b0, 4'd3, 32'h0000_0040, 8'd5},
        '{1'b1, 4'd4, 32'hDEAD_BEEF, 8'd7},  // R7
        '{1'b0, 4'd4, 32'hDEAD_BEEF, 8'd7},
        '{1'b1, 4'd6, 32'h0000_0000, 8'd9},  // R9 id is read-only
        '{1'b0, 4'd6, ID_EXP,        8'd9},
        '{1'b1, 4'd3, 32'h0000_FFFF, 8'd9},  // R9 status not writable
        '{1'b0, 4'd3, 32'h0000_0040, 8'd9},
        '{1'b1, 4'd9, 32'h0000_0055, 8'd9},  // R9 unused index
        '{1'b0, 4'd9, 32'h0000_0000, 8'd9},
        '{1'b1, 4'd1, 32'h0000_0001, 8'd6},  // R6 reg 1, link down
        '{1'b1, 4'd0, 32'h0000_0000, 8'd6},
        '{1'b1, 4'd0, 32'h0000_0001, 8'd6},
        '{1'b0, 4'd3, 32'h0000_0000, 8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        link_up = 1'b0;
    logic [31:0] flag_set = '0;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_mgmt_frontend uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .link_up  (link_up),
        .flag_set (flag_set)
    );

    task automatic do_write(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = idx;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_read(input logic [3:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_idx = idx;
        #1;
        total++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s idx %0d actual %h expected %h", req, idx, rd_data, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired, run incomplete");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 6; i++) check_read(4'(i), 32'h0, "R1");
        check_read(4'd6, ID_EXP, "R1");

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) do_write(VEC[i].idx, VEC[i].val);
            else check_read(VEC[i].idx, VEC[i].val, $sformatf("R%0d", VEC[i].req));
        end

        // R6 link up seen through PHY reg 1 (address still 1)
        @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        do_write(4'd0, 32'h0);
        do_write(4'd0, 32'h1);
        check_read(4'd3, 32'h0000_0004, "R6");
        link_up = 1'b0;
        @(negedge clk);
        do_write(4'd0, 32'h0);
        do_write(4'd0, 32'h1);
        check_read(4'd3, 32'h0000_0000, "R6");

        // R8 flag register
        @(negedge clk);
        flag_set = 32'h0000_0F0F;
        @(negedge clk);
        flag_set = 32'h0;
        check_read(4'd5, 32'h0000_0F0F, "R8");
        do_write(4'd5, 32'h0000_000F);
        check_read(4'd5, 32'h0000_0F00, "R8");
        do_write(4'd5, 32'h0000_0000);
        check_read(4'd5, 32'h0000_0F00, "R8");
        @(negedge clk);
        flag_set = 32'h0000_0001;
        wr_en    = 1'b1;
        wr_idx   = 4'd5;
        wr_data  = 32'h0000_0001;
        @(negedge clk);
        wr_en    = 1'b0;
        flag_set = 32'h0;
        check_read(4'd5, 32'h0000_0F01, "R8");

        // R1 reset in mid-run clears PHY control value
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_read(4'd4, 32'h0, "R1");
        check_read(4'd5, 32'h0, "R1");
        do_write(4'd0, 32'h1);   // address 0 after reset
        check_read(4'd3, 32'h0, "R1");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule